// File: doc/BRIEF.md
# Interrupt and Trap Entry Sequencer

This block is the multi-cycle control and datapath for entering and leaving service routines on a small 16-bit processor. It owns the processor status word and the two parked stack pointers: user and supervisor. At an instruction boundary it picks one of three jobs. The first is a device interrupt, which swaps stacks, pushes the PC and status word, raises privilege and priority, and jumps through a vector table. The second is a trap, which links the PC into R7 and jumps indirectly through a low-memory table. The third is a return from interrupt, which pops the status word and PC and swaps the stacks back when it returns to user mode.

It drives one word-wide synchronous memory port, used for stack pushes, stack pops and vector-table reads. It also drives write strobes for R6, R7 and the PC. The current PC and R6 come in from the register file. Requests that arrive while a sequence runs are dropped. Decode, the ALU and device registers sit outside.

Top module: `irq_trap_seq`

## Requirements
- R1: After reset the status word is 0x8002, which means user mode, priority 0 and the Z flag set. The parked supervisor pointer is 0x3000 and `busy` is low. While `busy` is low, none of `mem_we`, `mem_re`, `pc_we`, `r6_we` or `r7_we` is asserted.
- R2: An interrupt is accepted only when all of these hold in the same cycle:
  - `instr_done` is high;
  - `irq_req` is high;
  - `irq_en` is high;
  - `irq_prio` is strictly greater than status bits 10:8;
  - the block is not busy.
- R3: On interrupt entry, the PC is written to address SP-1 in the first cycle after acceptance. The status word is written to SP-2 in the second cycle. A memory read and a memory write never happen in the same cycle.
- R4: After the pushes, the status word has bit 15 at 0, bits 10:8 equal to the device priority, and every other bit at 0, condition codes included.
- R5: The third cycle of an interrupt entry reads address 0x0100 + vector. Read data returns on `mem_rdata` one cycle after `mem_re`. In that next cycle the PC is written with that word and R6 is written with SP-2.
- R6: If status bit 15 is set at acceptance, R6 is parked as the user pointer and SP is the parked supervisor pointer. Otherwise SP is the current R6 and the parked user pointer is left unchanged.
- R7: A trap reads address 0x0000 + trap vector. In that same cycle it writes R7 with the PC. In the next cycle it writes the PC with the returned word. It does no stack write and leaves the status word unchanged.
- R8: A return from interrupt issued in supervisor mode does the following:
  - it reads the status word at R6 and the PC at R6+1, in consecutive cycles;
  - it replaces the status word and the PC with the popped values;
  - if the popped bit 15 is 1, it parks R6+2 as the supervisor pointer and writes R6 with the parked user pointer;
  - otherwise it writes R6 with R6+2.
- R9: A return from interrupt issued in user mode pulses `priv_err` for exactly one cycle, the cycle after the boundary. It touches no memory, register or status.
- R10: `busy` is high from the cycle after acceptance through the cycle in which the PC is written. That is 4 cycles for an interrupt, 2 for a trap and 3 for a return. Boundaries and requests seen while busy are ignored.
- R11: When an interrupt and a trap are both valid at one boundary, the interrupt is taken. A trap still requested at a later boundary is then taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_done | input | 1 | Current instruction has completed |
| irq_req | input | 1 | Device requests service |
| irq_en | input | 1 | Device interrupt enable |
| irq_prio | input | 3 | Device priority level |
| irq_vec | input | 8 | Device vector index |
| trap_req | input | 1 | Trap requested by decode |
| trap_vec | input | 8 | Trap table index |
| rti_req | input | 1 | Return from interrupt requested |
| pc_in | input | 16 | Current PC |
| r6_in | input | 16 | Current R6 |
| mem_addr | output | 16 | Memory word address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after `mem_re` |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | 16 | New PC |
| r6_we | output | 1 | R6 write strobe |
| r6_wdata | output | 16 | New R6 |
| r7_we | output | 1 | R7 write strobe |
| r7_wdata | output | 16 | Link value for R7 |
| psr_out | output | 16 | Processor status word |
| busy | output | 1 | Sequence in progress |
| priv_err | output | 1 | Privilege violation pulse |

## Verification
The properties assume a few things about the surroundings:
- memory answers every read exactly one cycle after `mem_re`;
- `pc_in` and `r6_in` follow the strobes the block issues;
- `instr_done` is a single-cycle strobe from an instruction that has really completed.

The bench meets these assumptions with a registered memory model and a register-file model written only through the block's own strobes. It pulses the boundary for one cycle per attempt. The one deliberate exception is a boundary pulse, carrying every request at top priority, placed in the middle of an interrupt entry. Its purpose is to show that such a pulse is dropped. Requesters hold a pending trap themselves, so the bench reasserts the trap at the next boundary.

// File: rtl/irq_trap_pkg.sv
package irq_trap_pkg;

    // status word layout
    localparam int PSR_PRIV_BIT = 15;
    localparam int PSR_PRIO_LSB = 8;
    localparam int PSR_PRIO_W   = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_I_PUSH_PC,
        ST_I_PUSH_PSR,
        ST_I_VEC_RD,
        ST_I_LOAD,
        ST_T_VEC_RD,
        ST_T_LOAD,
        ST_R_POP_PSR,
        ST_R_POP_PC,
        ST_R_LOAD
    } seq_state_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_IRQ,
        SEL_TRAP,
        SEL_RTI
    } req_sel_e;

endpackage

// File: rtl/its_arbiter.sv
module its_arbiter
    import irq_trap_pkg::*;
#(
    parameter int PRIO_W = 3
) (
    input  logic              idle,
    input  logic              boundary,
    input  logic              irq_req,
    input  logic              irq_en,
    input  logic [PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic              trap_req,
    input  logic              rti_req,
    output req_sel_e          sel
);

    logic irq_ok;

    assign irq_ok = irq_req && irq_en && (irq_prio > cur_prio);

    // interrupt outranks trap, trap outranks return
    always_comb begin
        sel = SEL_NONE;
        if (idle && boundary) begin
            if (irq_ok) begin
                sel = SEL_IRQ;
            end else if (trap_req) begin
                sel = SEL_TRAP;
            end else if (rti_req) begin
                sel = SEL_RTI;
            end
        end
    end

endmodule

// File: rtl/its_vec_addr.sv
module its_vec_addr #(
    parameter int             AW    = 16,
    parameter int             VEC_W = 8,
    parameter logic [AW-1:0]  BASE  = '0
) (
    input  logic [VEC_W-1:0] vec,
    output logic [AW-1:0]    addr
);

    // aligned table base: splice the index in, otherwise add it
    generate
        if (BASE[VEC_W-1:0] == '0) begin : g_splice
            assign addr = {BASE[AW-1:VEC_W], vec};
        end else begin : g_add
            assign addr = BASE + AW'(vec);
        end
    endgenerate

endmodule

// File: rtl/irq_trap_seq.sv
module irq_trap_seq
    import irq_trap_pkg::*;
#(
    parameter int            DW       = 16,
    parameter int            VEC_W    = 8,
    parameter logic [DW-1:0] IVT_BASE = 16'h0100,
    parameter logic [DW-1:0] TVT_BASE = 16'h0000,
    parameter logic [DW-1:0] SSP_INIT = 16'h3000,
    parameter logic [DW-1:0] PSR_INIT = 16'h8002
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  instr_done,
    input  logic                  irq_req,
    input  logic                  irq_en,
    input  logic [PSR_PRIO_W-1:0] irq_prio,
    input  logic [VEC_W-1:0]      irq_vec,
    input  logic                  trap_req,
    input  logic [VEC_W-1:0]      trap_vec,
    input  logic                  rti_req,
    input  logic [DW-1:0]         pc_in,
    input  logic [DW-1:0]         r6_in,
    output logic [DW-1:0]         mem_addr,
    output logic                  mem_we,
    output logic                  mem_re,
    output logic [DW-1:0]         mem_wdata,
    input  logic [DW-1:0]         mem_rdata,
    output logic                  pc_we,
    output logic [DW-1:0]         pc_wdata,
    output logic                  r6_we,
    output logic [DW-1:0]         r6_wdata,
    output logic                  r7_we,
    output logic [DW-1:0]         r7_wdata,
    output logic [DW-1:0]         psr_out,
    output logic                  busy,
    output logic                  priv_err
);

    localparam int            PRIO_W = PSR_PRIO_W;
    localparam logic [DW-1:0] ONE    = DW'(1);

    typedef struct packed {
        seq_state_e        st;
        logic [DW-1:0]     psr;
        logic [DW-1:0]     ssp;
        logic [DW-1:0]     usp;
        logic [DW-1:0]     sp;
        logic [DW-1:0]     pc_save;
        logic [DW-1:0]     psr_save;
        logic [VEC_W-1:0]  vec;
        logic [PRIO_W-1:0] prio;
        logic              err;
    } seq_t;

    seq_t          q, d;
    req_sel_e      sel;
    logic [DW-1:0] ivt_addr;
    logic [DW-1:0] tvt_addr;
    logic [DW-1:0] psr_entry;

    its_arbiter #(.PRIO_W(PRIO_W)) arb_i (
        .idle     (q.st == ST_IDLE),
        .boundary (instr_done),
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .irq_prio (irq_prio),
        .cur_prio (q.psr[PSR_PRIO_LSB +: PRIO_W]),
        .trap_req (trap_req),
        .rti_req  (rti_req),
        .sel      (sel)
    );

    its_vec_addr #(.AW(DW), .VEC_W(VEC_W), .BASE(IVT_BASE)) ivt_i (
        .vec  (q.vec),
        .addr (ivt_addr)
    );

    its_vec_addr #(.AW(DW), .VEC_W(VEC_W), .BASE(TVT_BASE)) tvt_i (
        .vec  (q.vec),
        .addr (tvt_addr)
    );

    // privileged, device level, flags cleared
    always_comb begin
        psr_entry = '0;
        psr_entry[PSR_PRIO_LSB +: PRIO_W] = q.prio;
    end

    always_comb begin
        d         = q;
        d.err     = 1'b0;
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        pc_we     = 1'b0;
        pc_wdata  = mem_rdata;
        r6_we     = 1'b0;
        r6_wdata  = q.sp;
        r7_we     = 1'b0;
        r7_wdata  = q.pc_save;

        case (q.st)
            ST_IDLE: begin
                case (sel)
                    SEL_IRQ: begin
                        d.pc_save  = pc_in;
                        d.psr_save = q.psr;
                        d.vec      = irq_vec;
                        d.prio     = irq_prio;
                        if (q.psr[PSR_PRIV_BIT]) begin
                            d.usp = r6_in;
                            d.sp  = q.ssp - ONE;
                        end else begin
                            d.sp  = r6_in - ONE;
                        end
                        d.st = ST_I_PUSH_PC;
                    end
                    SEL_TRAP: begin
                        d.pc_save = pc_in;
                        d.vec     = trap_vec;
                        d.st      = ST_T_VEC_RD;
                    end
                    SEL_RTI: begin
                        if (q.psr[PSR_PRIV_BIT]) begin
                            d.err = 1'b1;
                        end else begin
                            d.sp = r6_in;
                            d.st = ST_R_POP_PSR;
                        end
                    end
                    default: ;
                endcase
            end

            ST_I_PUSH_PC: begin
                mem_we    = 1'b1;
                mem_addr  = q.sp;
                mem_wdata = q.pc_save;
                d.sp      = q.sp - ONE;
                d.st      = ST_I_PUSH_PSR;
            end

            ST_I_PUSH_PSR: begin
                mem_we    = 1'b1;
                mem_addr  = q.sp;
                mem_wdata = q.psr_save;
                d.psr     = psr_entry;
                d.st      = ST_I_VEC_RD;
            end

            ST_I_VEC_RD: begin
                mem_re   = 1'b1;
                mem_addr = ivt_addr;
                d.st     = ST_I_LOAD;
            end

            ST_I_LOAD: begin
                pc_we = 1'b1;
                r6_we = 1'b1;
                d.st  = ST_IDLE;
            end

            ST_T_VEC_RD: begin
                mem_re   = 1'b1;
                mem_addr = tvt_addr;
                r7_we    = 1'b1;
                d.st     = ST_T_LOAD;
            end

            ST_T_LOAD: begin
                pc_we = 1'b1;
                d.st  = ST_IDLE;
            end

            ST_R_POP_PSR: begin
                mem_re   = 1'b1;
                mem_addr = q.sp;
                d.sp     = q.sp + ONE;
                d.st     = ST_R_POP_PC;
            end

            ST_R_POP_PC: begin
                d.psr    = mem_rdata;
                mem_re   = 1'b1;
                mem_addr = q.sp;
                d.sp     = q.sp + ONE;
                d.st     = ST_R_LOAD;
            end

            ST_R_LOAD: begin
                pc_we = 1'b1;
                r6_we = 1'b1;
                if (q.psr[PSR_PRIV_BIT]) begin
                    d.ssp    = q.sp;
                    r6_wdata = q.usp;
                end
                d.st = ST_IDLE;
            end

            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st       <= ST_IDLE;
            q.psr      <= PSR_INIT;
            q.ssp      <= SSP_INIT;
            q.usp      <= '0;
            q.sp       <= '0;
            q.pc_save  <= '0;
            q.psr_save <= '0;
            q.vec      <= '0;
            q.prio     <= '0;
            q.err      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign psr_out  = q.psr;
    assign busy     = (q.st != ST_IDLE);
    assign priv_err = q.err;

endmodule

// File: rtl/irq_trap_seq_chk.sv
module irq_trap_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_done,
    input logic        busy,
    input logic        mem_we,
    input logic        mem_re,
    input logic        pc_we,
    input logic        r6_we,
    input logic        r7_we,
    input logic        priv_err,
    input logic [15:0] psr_out
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_we || mem_re || pc_we || r6_we || r7_we));

    // R3
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R2
    entry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(instr_done));

    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_err |=> !priv_err);

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_err |-> !busy && $stable(psr_out));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !pc_we |=> busy);

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> !busy);

    // R4
    psr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !$past(busy) |-> $stable(psr_out));

endmodule

bind irq_trap_seq irq_trap_seq_chk chk_i (.*);

// File: tb/irq_trap_seq_tb_top.sv
`timescale 1ns/1ps
module irq_trap_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_done = 1'b0;
    logic        irq_req = 1'b0;
    logic        irq_en = 1'b0;
    logic [2:0]  irq_prio = '0;
    logic [7:0]  irq_vec = '0;
    logic        trap_req = 1'b0;
    logic [7:0]  trap_vec = '0;
    logic        rti_req = 1'b0;
    logic [15:0] mem_addr, mem_wdata, pc_wdata, r6_wdata, r7_wdata, psr_out;
    logic        mem_we, mem_re, pc_we, r6_we, r7_we, busy, priv_err;
    logic [15:0] mem_rdata = '0;
    logic [15:0] pc_reg = 16'h3100;
    logic [15:0] r6_reg = 16'h4000;
    logic [15:0] r7_reg = 16'h0000;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_trap_seq dut_i (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done),
        .irq_req(irq_req), .irq_en(irq_en), .irq_prio(irq_prio), .irq_vec(irq_vec),
        .trap_req(trap_req), .trap_vec(trap_vec), .rti_req(rti_req),
        .pc_in(pc_reg), .r6_in(r6_reg),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pc_we(pc_we), .pc_wdata(pc_wdata), .r6_we(r6_we), .r6_wdata(r6_wdata),
        .r7_we(r7_we), .r7_wdata(r7_wdata),
        .psr_out(psr_out), .busy(busy), .priv_err(priv_err)
    );

    // memory and register-file models
    logic [15:0] mem [int];

    always @(posedge clk) begin
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
        if (mem_re) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'hDEAD;
        if (pc_we) pc_reg <= pc_wdata;
        if (r6_we) r6_reg <= r6_wdata;
        if (r7_we) r7_reg <= r7_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // scoreboard: 0 write, 1 read, 2 R7, 3 PC, 4 R6, 5 privilege error
    typedef struct {
        int          kind;
        logic [15:0] a;
        logic [15:0] d;
        string       req;
    } ev_t;

    ev_t expq[$];

    task automatic expect_ev(input int k, input logic [15:0] a, input logic [15:0] dv,
                             input string req);
        ev_t e;
        e.kind = k; e.a = a; e.d = dv; e.req = req;
        expq.push_back(e);
    endtask

    task automatic seen(input int k, input logic [15:0] a, input logic [15:0] dv);
        ev_t e;
        if (expq.size() == 0) begin
            chk(1'b0, "R10", "unexpected event kind", k, 32'hFFFF);
        end else begin
            e = expq.pop_front();
            chk(e.kind == k, e.req, "event kind", k, e.kind);
            chk(e.a == a, e.req, "event address", a, e.a);
            chk(e.d == dv, e.req, "event data", dv, e.d);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we)   seen(0, mem_addr, mem_wdata);
            if (mem_re)   seen(1, mem_addr, 16'h0);
            if (r7_we)    seen(2, 16'h0, r7_wdata);
            if (pc_we)    seen(3, 16'h0, pc_wdata);
            if (r6_we)    seen(4, 16'h0, r6_wdata);
            if (priv_err) seen(5, 16'h0, 16'h0);
        end
    end

    // reference model of architectural state
    logic [15:0] psr_m = 16'h8002;
    logic [15:0] ssp_m = 16'h3000;
    logic [15:0] usp_m = 16'h0000;
    logic [15:0] r6_m  = 16'h4000;
    logic [15:0] pc_m  = 16'h3100;

    task automatic exp_irq(input logic [2:0] pr, input logic [7:0] v);
        logic [15:0] sp;
        logic [15:0] tgt;
        if (psr_m[15]) begin
            usp_m = r6_m;
            sp = ssp_m;
        end else begin
            sp = r6_m;
        end
        tgt = mem[32'h100 + int'(v)];
        expect_ev(0, sp - 16'd1, pc_m, "R3");
        expect_ev(0, sp - 16'd2, psr_m, "R3");
        expect_ev(1, 16'h0100 + {8'h0, v}, 16'h0, "R5");
        expect_ev(3, 16'h0, tgt, "R5");
        expect_ev(4, 16'h0, sp - 16'd2, "R6");
        psr_m = {5'b0, pr, 8'h00};
        pc_m = tgt;
        r6_m = sp - 16'd2;
    endtask

    task automatic exp_trap(input logic [7:0] v);
        logic [15:0] tgt;
        tgt = mem[int'(v)];
        expect_ev(1, {8'h0, v}, 16'h0, "R7");
        expect_ev(2, 16'h0, pc_m, "R7");
        expect_ev(3, 16'h0, tgt, "R7");
        pc_m = tgt;
    endtask

    task automatic exp_rti();
        logic [15:0] sp;
        logic [15:0] p;
        logic [15:0] c;
        if (psr_m[15]) begin
            expect_ev(5, 16'h0, 16'h0, "R9");
        end else begin
            sp = r6_m;
            p = mem[int'(sp)];
            c = mem[int'(sp + 16'd1)];
            expect_ev(1, sp, 16'h0, "R8");
            expect_ev(1, sp + 16'd1, 16'h0, "R8");
            expect_ev(3, 16'h0, c, "R8");
            if (p[15]) begin
                expect_ev(4, 16'h0, usp_m, "R6");
                ssp_m = sp + 16'd2;
                r6_m = usp_m;
            end else begin
                expect_ev(4, 16'h0, sp + 16'd2, "R8");
                r6_m = sp + 16'd2;
            end
            psr_m = p;
            pc_m = c;
        end
    endtask

    task automatic clear_inputs();
        instr_done = 1'b0; irq_req = 1'b0; irq_en = 1'b0; irq_prio = '0;
        irq_vec = '0; trap_req = 1'b0; trap_vec = '0; rti_req = 1'b0;
    endtask

    task automatic strobe(input bit ir, input logic [2:0] pr, input logic [7:0] iv,
                          input bit ien, input bit tr, input logic [7:0] tv,
                          input bit rr, input bit bnd, input int exp_busy,
                          input bit poke, input string req);
        int n;
        @(negedge clk);
        irq_req = ir; irq_prio = pr; irq_vec = iv; irq_en = ien;
        trap_req = tr; trap_vec = tv; rti_req = rr; instr_done = bnd;
        @(negedge clk);
        clear_inputs();
        n = 0;
        while (busy && n < 40) begin
            if (poke && n == 1) begin
                instr_done = 1'b1; irq_req = 1'b1; irq_en = 1'b1; irq_prio = 3'd7;
                trap_req = 1'b1; rti_req = 1'b1;
            end else begin
                clear_inputs();
            end
            n++;
            @(negedge clk);
        end
        clear_inputs();
        repeat (2) @(negedge clk);
        chk(n == exp_busy, req, "busy cycles", n, exp_busy);
    endtask

    task automatic post(input string req);
        chk(psr_out == psr_m, req, "status word", psr_out, psr_m);
        chk(r6_reg == r6_m, req, "R6", r6_reg, r6_m);
        chk(pc_reg == pc_m, req, "PC", pc_reg, pc_m);
        chk(expq.size() == 0, req, "missing events", expq.size(), 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        logic [15:0] old_pc;
        for (int v = 0; v < 256; v++) begin
            mem[32'h100 + v] = 16'h1000 + 16'(v * 16);
            mem[v] = 16'h0400 + 16'(v * 2);
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(psr_out == 16'h8002, "R1", "reset status", psr_out, 16'h8002);
        chk(busy == 1'b0, "R1", "reset busy", busy, 0);
        chk(priv_err == 1'b0, "R1", "reset priv_err", priv_err, 0);
        chk(!(mem_we || mem_re || pc_we || r6_we || r7_we), "R1", "idle strobes",
            {mem_we, mem_re, pc_we, r6_we, r7_we}, 0);

        // R2: disabled, equal priority, no boundary
        strobe(1, 3'd5, 8'h11, 0, 0, 8'h0, 0, 1, 0, 0, "R2");
        post("R2");
        strobe(1, 3'd0, 8'h12, 1, 0, 8'h0, 0, 1, 0, 0, "R2");
        post("R2");
        strobe(1, 3'd5, 8'h13, 1, 0, 8'h0, 0, 0, 0, 0, "R2");
        post("R2");

        // R3 R4 R5 R6 entry from user, with a boundary pulse mid-sequence (R10)
        exp_irq(3'd4, 8'h21);
        strobe(1, 3'd4, 8'h21, 1, 0, 8'h0, 0, 1, 4, 1, "R10");
        post("R4");
        chk(psr_out == 16'h0400, "R4", "entry status", psr_out, 16'h0400);

        // R2 lower priority while serviced
        strobe(1, 3'd3, 8'h07, 1, 0, 8'h0, 0, 1, 0, 0, "R2");
        post("R2");

        // R6 nested entry from supervisor: no swap
        exp_irq(3'd6, 8'h05);
        strobe(1, 3'd6, 8'h05, 1, 0, 8'h0, 0, 1, 4, 0, "R6");
        post("R6");

        // R7 trap
        old_pc = pc_m;
        exp_trap(8'h25);
        strobe(0, 3'd0, 8'h0, 0, 1, 8'h25, 0, 1, 2, 0, "R7");
        post("R7");
        chk(r7_reg == old_pc, "R7", "link register", r7_reg, old_pc);
        chk(psr_out == 16'h0600, "R7", "status kept", psr_out, 16'h0600);

        // R8 return to supervisor, then to user
        exp_rti();
        strobe(0, 3'd0, 8'h0, 0, 0, 8'h0, 1, 1, 3, 0, "R8");
        post("R8");
        exp_rti();
        strobe(0, 3'd0, 8'h0, 0, 0, 8'h0, 1, 1, 3, 0, "R8");
        post("R8");
        chk(r6_reg == 16'h4000, "R6", "user stack restored", r6_reg, 16'h4000);

        // R9 return in user mode
        exp_rti();
        strobe(0, 3'd0, 8'h0, 0, 0, 8'h0, 1, 1, 0, 0, "R9");
        post("R9");

        // R11 interrupt and trap together, trap taken later
        exp_irq(3'd2, 8'h10);
        strobe(1, 3'd2, 8'h10, 1, 1, 8'h30, 0, 1, 4, 0, "R11");
        post("R11");
        exp_trap(8'h30);
        strobe(0, 3'd0, 8'h0, 0, 1, 8'h30, 0, 1, 2, 0, "R11");
        post("R11");
        exp_rti();
        strobe(0, 3'd0, 8'h0, 0, 0, 8'h0, 1, 1, 3, 0, "R8");
        post("R8");

        summary();
        $finish;
    end

endmodule